// File: doc/BRIEF.md
# H-Bridge Gate Sequencer

This block turns a speed command (`pwm_in`) and a rotation command (`dir_in`) into four gate-enable levels for a full H-bridge. In either direction one high-side switch stays on. The opposite leg is chopped as a complementary pair: the low side follows the PWM and the high side follows its inverse. An enable is formed from five status inputs. Without it every gate is off.

A clock-counted non-overlap gap, loaded from `dead_cycles`, is inserted before any gate turns on. The gap starts on every change of `pwm_in` or `dir_in`, and also when drive resumes after a disable or a fault. Gates that must turn off do so at once.

Five qualification filters watch the desaturation flags of the four switches and a supply-drop flag. A desaturation flag is only counted while its switch is on and no gap is running. If a counted flag stays high for `SC_CYCLES` consecutive clocks, the block latches a short-circuit fault. The fault blanks all gates and raises `sc_diag`. It clears on the next edge of `pwm_in`, after which drive resumes through a fresh gap.

The controller has four states:
- `ST_OFF`: enable low.
- `ST_DEAD`: gap counting.
- `ST_DRIVE`: steady drive.
- `ST_FAULT`: latched short circuit.

Its transitions are:
- OFF→DEAD (enable rises, gap > 0).
- OFF→DRIVE (enable rises, gap = 0).
- DRIVE→DEAD (input change, gap > 0).
- DEAD→DEAD restart (input change during the gap).
- DEAD→DRIVE (gap expires, or input change with gap = 0).
- DEAD/DRIVE→OFF (enable falls).
- any→FAULT (filter trip; a trip outranks the loss of enable).
- FAULT→DEAD, FAULT→DRIVE or FAULT→OFF (PWM edge, chosen by gap and enable).

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: The enable is `sync_ok & ~uv_flag & ~ov_flag & cp_ok & ~ot_shdn`. One clock after it is low, `gate_on` is 4'b0000 whatever `dir_in` and `pwm_in` are.
- R2: The gate bits are [0]=high side 1, [1]=low side 1, [2]=high side 2, [3]=low side 2. In steady drive with `dir_in`=0, `gate_on` = {pwm, ~pwm, 0, 1}.
- R3: In steady drive with `dir_in`=1, `gate_on` = {0, 1, pwm, ~pwm}.
- R4: The clock edge that first sees a change on `pwm_in` or `dir_in` turns off every gate not wanted by the new command. Newly wanted gates turn on `dead_cycles` edges later, or on that same edge when `dead_cycles` is 0. A further change during the gap restarts it. A high side and a low side of one leg are never on together.
- R5: A desaturation flag on a switch that is on and driving, held for `SC_CYCLES` consecutive edges, makes `gate_on` 0 and `sc_diag` 1 on that last edge. One edge fewer does not trip.
- R6: Desaturation flags are ignored for switches that are off and for the whole non-overlap gap. A flag that drops for one edge restarts its count from zero.
- R7: `supply_drop` held for `SC_CYCLES` consecutive edges trips the same fault, in any state but the fault state.
- R8: The fault holds until an edge of `pwm_in`; a change of `dir_in` alone does not clear it. On the clearing edge `sc_diag` falls and the gates stay off. Drive then resumes in the direction then commanded, after `dead_cycles` edges.
- R9: With `pwm_in` held high, the drive stays at 100% duty indefinitely in either direction, with no gap and no gate change.
- R10: During reset `gate_on` is 0 and `sc_diag` is 0. After reset, with enable high, the commanded gates turn on `dead_cycles` edges after the first clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | Speed command |
| dir_in | input | 1 | Rotation command |
| sync_ok | input | 1 | Trigger accepted |
| uv_flag | input | 1 | Supply undervoltage |
| ov_flag | input | 1 | Supply overvoltage |
| cp_ok | input | 1 | Charge pump ready |
| ot_shdn | input | 1 | Overtemperature shutdown |
| dead_cycles | input | DT_W | Non-overlap gap in clock cycles |
| desat | input | 4 | Per-switch desaturation flags, same bit order as gate_on |
| supply_drop | input | 1 | Bridge supply collapse flag |
| gate_on | output | 4 | Gate enables: [0] HS1, [1] LS1, [2] HS2, [3] LS2 |
| sc_diag | output | 1 | Short-circuit fault latched |

## Verification
Two functions can meet on one edge: a PWM transition that starts a non-overlap gap, and a desaturation count that is about to expire on a switch that stays on through that gap. The bench raises the flag on the surviving high side only after the gap has begun and holds it longer than the filter time, but drops it before the gap ends. It then checks that the late-turning switch comes on at the expected edge and that no fault is flagged. A second case toggles only `dir_in` while the fault is latched and checks that the latch survives until a real PWM edge. Each expected edge is counted from the edge that first samples the new input.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_DEAD  = 2'd1,
        ST_DRIVE = 2'd2,
        ST_FAULT = 2'd3
    } hb_state_e;

    localparam int unsigned NGATE = 4;
    localparam int unsigned NFILT = NGATE + 1;
    localparam int unsigned GI_HS1 = 0;
    localparam int unsigned GI_LS1 = 1;
    localparam int unsigned GI_HS2 = 2;
    localparam int unsigned GI_LS2 = 3;
endpackage

// File: rtl/hbg_steer.sv
module hbg_steer
    import hbg_pkg::*;
(
    input  logic             pwm,
    input  logic             dir,
    input  logic             sync_ok,
    input  logic             uv_flag,
    input  logic             ov_flag,
    input  logic             cp_ok,
    input  logic             ot_shdn,
    output logic [NGATE-1:0] target,
    output logic             master_en
);
    assign master_en = sync_ok & ~uv_flag & ~ov_flag & cp_ok & ~ot_shdn;

    always_comb begin
        target = '0;
        if (!dir) begin
            target[GI_HS1] = 1'b1;
            target[GI_HS2] = ~pwm;
            target[GI_LS2] = pwm;
        end else begin
            target[GI_HS2] = 1'b1;
            target[GI_HS1] = ~pwm;
            target[GI_LS1] = pwm;
        end
    end
endmodule

// File: rtl/hbg_trip_filter.sv
module hbg_trip_filter #(
    parameter int unsigned SC_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic qual,
    output logic trip
);
    localparam int unsigned CW = $clog2(SC_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(SC_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    assign trip = qual && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!qual || trip)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CW'(1);
    end

    // R6: a gap in the qualified flag restarts the count
    assert_filter_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !qual |=> cnt_q == '0);
endmodule

// File: rtl/hbridge_gate_ctrl.sv
module hbridge_gate_ctrl
    import hbg_pkg::*;
#(
    parameter int unsigned DT_W      = 8,
    parameter int unsigned SC_CYCLES = 2000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_in,
    input  logic             dir_in,
    input  logic             sync_ok,
    input  logic             uv_flag,
    input  logic             ov_flag,
    input  logic             cp_ok,
    input  logic             ot_shdn,
    input  logic [DT_W-1:0]  dead_cycles,
    input  logic [NGATE-1:0] desat,
    input  logic             supply_drop,
    output logic [NGATE-1:0] gate_on,
    output logic             sc_diag
);
    hb_state_e        state_q, state_d;
    logic [DT_W-1:0]  cnt_q, cnt_d;
    logic [NGATE-1:0] gate_q, gate_d;
    logic             pwm_q, dir_q;
    logic [NGATE-1:0] target;
    logic             master_en;
    logic [NFILT-1:0] qual, trip;
    logic             sc_hit, pwm_chg, cmd_chg, gap_zero;

    hbg_steer u_steer (
        .pwm       (pwm_in),
        .dir       (dir_in),
        .sync_ok   (sync_ok),
        .uv_flag   (uv_flag),
        .ov_flag   (ov_flag),
        .cp_ok     (cp_ok),
        .ot_shdn   (ot_shdn),
        .target    (target),
        .master_en (master_en)
    );

    for (genvar i = 0; i < NFILT; i++) begin : g_filt
        if (i < NGATE) begin : g_desat
            assign qual[i] = desat[i] && gate_q[i] && (state_q == ST_DRIVE);
        end else begin : g_supply
            assign qual[i] = supply_drop && (state_q != ST_FAULT);
        end
        hbg_trip_filter #(.SC_CYCLES(SC_CYCLES)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .qual  (qual[i]),
            .trip  (trip[i])
        );
    end

    assign sc_hit   = |trip;
    assign pwm_chg  = pwm_in != pwm_q;
    assign cmd_chg  = pwm_chg || (dir_in != dir_q);
    assign gap_zero = dead_cycles == '0;

    // next-state process
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_OFF: begin
                if (sc_hit)
                    state_d = ST_FAULT;
                else if (master_en) begin
                    state_d = gap_zero ? ST_DRIVE : ST_DEAD;
                    cnt_d   = dead_cycles;
                end
            end
            ST_DEAD: begin
                if (sc_hit)
                    state_d = ST_FAULT;
                else if (!master_en)
                    state_d = ST_OFF;
                else if (cmd_chg) begin
                    state_d = gap_zero ? ST_DRIVE : ST_DEAD;
                    cnt_d   = dead_cycles;
                end else if (cnt_q <= DT_W'(1))
                    state_d = ST_DRIVE;
                else
                    cnt_d = cnt_q - DT_W'(1);
            end
            ST_DRIVE: begin
                if (sc_hit)
                    state_d = ST_FAULT;
                else if (!master_en)
                    state_d = ST_OFF;
                else if (cmd_chg && !gap_zero) begin
                    state_d = ST_DEAD;
                    cnt_d   = dead_cycles;
                end
            end
            ST_FAULT: begin
                if (pwm_chg) begin
                    if (!master_en)
                        state_d = ST_OFF;
                    else begin
                        state_d = gap_zero ? ST_DRIVE : ST_DEAD;
                        cnt_d   = dead_cycles;
                    end
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // output process
    always_comb begin
        unique case (state_d)
            ST_DRIVE: gate_d = target;
            ST_DEAD:  gate_d = gate_q & target;
            default:  gate_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
            gate_q  <= '0;
            pwm_q   <= 1'b0;
            dir_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            gate_q  <= gate_d;
            pwm_q   <= pwm_in;
            dir_q   <= dir_in;
        end
    end

    assign gate_on = gate_q;
    assign sc_diag = (state_q == ST_FAULT);

    assert_off_when_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> gate_q == '0);

    assert_no_shoot_through_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_q[GI_HS1] && gate_q[GI_LS1]) && !(gate_q[GI_HS2] && gate_q[GI_LS2]));

    assert_turn_on_after_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(gate_q & ~$past(gate_q))) && ($past(dead_cycles) != '0))
            |-> $past(state_q) == ST_DEAD);

    assert_trip_blanks_gates_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sc_diag) |-> gate_q == '0);

    assert_clear_on_pwm_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sc_diag) |-> $past(pwm_in) != $past(pwm_q));
endmodule

// File: tb/sim_hbridge_gate_ctrl.sv
`timescale 1ns/1ps
module sim_hbridge_gate_ctrl;
    localparam int unsigned DT_W = 8;
    localparam int unsigned SC   = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pwm_in = 1'b0, dir_in = 1'b0;
    logic            sync_ok = 1'b0, uv_flag = 1'b0, ov_flag = 1'b0;
    logic            cp_ok = 1'b0, ot_shdn = 1'b0;
    logic [DT_W-1:0] dead_cycles = 8'd3;
    logic [3:0]      desat = 4'b0;
    logic            supply_drop = 1'b0;
    logic [3:0]      gate_on;
    logic            sc_diag;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hbridge_gate_ctrl #(.DT_W(DT_W), .SC_CYCLES(SC)) u0 (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .dir_in(dir_in),
        .sync_ok(sync_ok), .uv_flag(uv_flag), .ov_flag(ov_flag),
        .cp_ok(cp_ok), .ot_shdn(ot_shdn), .dead_cycles(dead_cycles),
        .desat(desat), .supply_drop(supply_drop),
        .gate_on(gate_on), .sc_diag(sc_diag)
    );

    // {sync,uv,ov,cp,ot}, dir, pwm, expected gate_on
    localparam logic [10:0] VEC [10] = '{
        11'b10010_0_0_0101,
        11'b10010_0_1_1001,
        11'b10010_1_0_0101,
        11'b10010_1_1_0110,
        11'b00010_1_1_0000,
        11'b11010_1_1_0000,
        11'b10110_0_1_0000,
        11'b10000_0_1_0000,
        11'b10011_0_0_0000,
        11'b10010_0_1_1001
    };

    task automatic check(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int bad;
        tick(3);
        check("R10 reset gates", gate_on, 4'b0000);
        check("R10 reset diag", {3'b0, sc_diag}, 4'b0000);
        rst_n = 1'b1;
        {sync_ok, uv_flag, ov_flag, cp_ok, ot_shdn} = 5'b10010;
        tick(3);
        check("R10 gap after reset", gate_on, 4'b0000);
        tick(1);
        check("R10 first drive", gate_on, 4'b0101);

        for (int i = 0; i < 10; i++) begin
            {sync_ok, uv_flag, ov_flag, cp_ok, ot_shdn, dir_in, pwm_in} = VEC[i][10:4];
            tick(8);
            check($sformatf("R1/R2/R3 table row %0d", i), gate_on, VEC[i][3:0]);
        end

        // R4: gap timing, dir0 pwm 1->0
        pwm_in = 1'b0;
        tick(1);
        check("R4 immediate turn-off", gate_on, 4'b0001);
        tick(2);
        check("R4 still in gap", gate_on, 4'b0001);
        tick(1);
        check("R4 turn-on after gap", gate_on, 4'b0101);
        // R4: zero gap
        dead_cycles = 8'd0;
        pwm_in = 1'b1;
        tick(1);
        check("R4 zero gap", gate_on, 4'b1001);
        // R4: restart of gap
        dead_cycles = 8'd3;
        pwm_in = 1'b0;
        tick(1);
        check("R4 restart first", gate_on, 4'b0001);
        pwm_in = 1'b1;
        tick(3);
        check("R4 restart held", gate_on, 4'b0001);
        tick(1);
        check("R4 restart done", gate_on, 4'b1001);

        // R5: desat on LS2 while on
        desat = 4'b1000;
        tick(SC - 1);
        check("R5 no early trip", {sc_diag, gate_on[2:0]}, 4'b0001);
        tick(1);
        check("R5 trip gates", gate_on, 4'b0000);
        check("R5 trip diag", {3'b0, sc_diag}, 4'b0001);
        desat = 4'b0000;

        // R8: dir alone does not clear
        dir_in = 1'b1;
        tick(4);
        check("R8 dir keeps fault", {sc_diag, gate_on[2:0]}, 4'b1000);
        pwm_in = 1'b0;
        tick(1);
        check("R8 clear on pwm edge", {sc_diag, gate_on[2:0]}, 4'b0000);
        tick(2);
        check("R8 gap after clear", gate_on, 4'b0000);
        tick(1);
        check("R8 resume dir1", gate_on, 4'b0101);

        // R6: flags on switches that are off
        pwm_in = 1'b1;
        tick(5);
        check("R6 setup", gate_on, 4'b0110);
        desat = 4'b1001;
        tick(20);
        check("R6 off-switch flags ignored", {sc_diag, gate_on[2:0]}, 4'b0110);
        desat = 4'b0000;
        // R6: broken flag restarts count
        desat = 4'b0010;
        tick(SC - 1);
        desat = 4'b0000;
        tick(1);
        desat = 4'b0010;
        tick(SC - 1);
        desat = 4'b0000;
        tick(1);
        check("R6 broken flag no trip", {sc_diag, gate_on[2:0]}, 4'b0110);
        // R6: flag during gap on surviving HS2
        dead_cycles = 8'd10;
        pwm_in = 1'b0;
        tick(1);
        check("R6 gap start", gate_on, 4'b0100);
        desat = 4'b0100;
        tick(8);
        desat = 4'b0000;
        tick(1);
        check("R6 gap flag ignored", {sc_diag, gate_on[2:0]}, 4'b0100);
        tick(1);
        check("R6 turn-on after gap", gate_on, 4'b0101);
        dead_cycles = 8'd3;

        // R7: supply drop
        supply_drop = 1'b1;
        tick(SC - 1);
        check("R7 no early trip", {3'b0, sc_diag}, 4'b0000);
        tick(1);
        check("R7 trip", {sc_diag, gate_on[2:0]}, 4'b1000);
        supply_drop = 1'b0;
        pwm_in = 1'b1;
        tick(4);
        check("R8 clear after supply trip", {sc_diag, gate_on[2:0]}, 4'b0110);

        // R9: 100% duty both directions
        bad = 0;
        for (int k = 0; k < 100; k++) begin
            tick(1);
            if (gate_on !== 4'b0110) bad++;
        end
        check("R9 full duty dir1", 4'(bad), 4'd0);
        dir_in = 1'b0;
        tick(5);
        bad = 0;
        for (int k = 0; k < 100; k++) begin
            tick(1);
            if (gate_on !== 4'b1001) bad++;
        end
        check("R9 full duty dir0", 4'(bad), 4'd0);

        // R1: enable loss during drive
        ot_shdn = 1'b1;
        tick(1);
        check("R1 shutdown one edge", gate_on, 4'b0000);
        ot_shdn = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule